// File: doc/BRIEF.md
# Posted-Write Window Bridge

This block sits between an AXI write slave port and a command port toward a downstream link. Every write is taken as one address and one data beat, accepted together. Each write address is compared against a small set of programmable address windows. If it falls inside an enabled window, the write goes out as a posted command. Its upper address field is replaced by the window's translated value, and the AXI B response is produced on the next cycle without waiting for the link.

A write that falls in no enabled window goes out unchanged as a non-posted command. It carries a slot tag. Its B response is held back until the link returns a completion for that tag. A small table of outstanding non-posted writes remembers the AXI ID of each one. Completions may come back in any order, and B responses leave in the order the completions arrive.

A configuration write port programs three registers per window: control, base and mask. A per-window unpack flag is stored in the control register and driven out to neighbouring logic. It has no effect on posting.

Top module: `pwb_bridge`

## Requirements
- R1: After reset every window is disabled, `unpack_en` is all zero, and `s_bvalid` and `cmd_valid` are low. A write to any address is then handled as non-posted.
- R2: A window hits when its enable bit (bit 31 of control) is set and `(addr & mask) == (base & mask)`. A hit drives `cmd_posted`=1. `cfg_sel` encodes control=0, base=1, mask=2.
- R3: A posted write raises `s_bvalid` in the cycle after AW/W acceptance, with `s_bid` equal to its `s_awid` and `s_bresp`=2'b00.
- R4: On a hit, `cmd_addr[39:24]` equals control bits [15:0] of the hit window, and `cmd_addr[23:0]` equals the incoming address. On a miss, `cmd_addr` equals `s_awaddr`.
- R5: A non-posted write drives `cmd_posted`=0 and gives no B response until a completion carrying its `cmd_tag` is taken. `s_bvalid` then rises in the next cycle with the stored ID, and `s_bresp` is 2'b10 if `cpl_err` was set and 2'b00 otherwise.
- R6: When several enabled windows hit, the lowest-numbered window supplies the translated address.
- R7: At most 4 non-posted writes are outstanding. A further miss is not accepted until a completion frees a slot, and the freed lowest slot is reused. B responses follow completion order.
- R8: AW and W are accepted only in the same cycle and only while `cmd_ready` is high. While `cmd_ready` is low, no write is accepted and no early B response is produced.
- R9: Control bit 30 of each window is driven on `unpack_en[w]`. It does not change whether a write is posted.
- R10: `s_bvalid` and `s_bid` hold until `s_bready`. While a B response is pending, no posted write is accepted and `cpl_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_win | input | WIN_W | Window index for configuration write |
| cfg_sel | input | 2 | Register select: 0 control, 1 base, 2 mask |
| cfg_wdata | input | ADDR_W | Configuration write data |
| unpack_en | output | NWIN | Per-window unpack flag (control bit 30) |
| s_awvalid | input | 1 | AXI write address valid |
| s_awready | output | 1 | AXI write address ready |
| s_awid | input | ID_W | AXI write ID |
| s_awaddr | input | ADDR_W | AXI write address |
| s_wvalid | input | 1 | AXI write data valid |
| s_wready | output | 1 | AXI write data ready |
| s_wdata | input | DATA_W | AXI write data |
| s_wstrb | input | DATA_W/8 | AXI write byte strobes |
| s_bvalid | output | 1 | AXI write response valid |
| s_bready | input | 1 | AXI write response ready |
| s_bid | output | ID_W | AXI write response ID |
| s_bresp | output | 2 | AXI write response code |
| cmd_valid | output | 1 | Link command valid |
| cmd_ready | input | 1 | Link command ready |
| cmd_posted | output | 1 | 1 posted write, 0 non-posted write |
| cmd_addr | output | ADDR_W | Outgoing (possibly translated) address |
| cmd_data | output | DATA_W | Outgoing write data |
| cmd_strb | output | DATA_W/8 | Outgoing byte strobes |
| cmd_tag | output | TAG_W | Slot tag of a non-posted command |
| cpl_valid | input | 1 | Link completion valid |
| cpl_ready | output | 1 | Completion accepted |
| cpl_tag | input | TAG_W | Tag of the completed command |
| cpl_err | input | 1 | Completion reports an error |

## Verification
The bench sweeps all four window-enable combinations against addresses inside each window, inside the other window and outside both. A broken hit test or a wrong translation shows up as a wrong posted flag or a wrong upper address field. Overlapping windows catch a priority inversion, which would put the higher window's translation on the command. The bench fills all four non-posted slots and completes them out of order. A design that miscounted would accept the fifth write or return the wrong ID. Stalls on `cmd_ready` and on `s_bready` catch a design that acknowledged early or dropped a pending response. The unpack-only control value catches a design that confused bit 30 with the enable.

// File: rtl/pwb_pkg.sv
// Shared definitions for the posted-write window bridge.
// Assumes control register fields at fixed bit positions, as listed below.
package pwb_pkg;
    typedef enum logic [1:0] {
        CFG_CTRL = 2'd0,
        CFG_BASE = 2'd1,
        CFG_MASK = 2'd2
    } pwb_cfg_sel_e;

    localparam int CTRL_EN_BIT   = 31;
    localparam int CTRL_UNPK_BIT = 30;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;
endpackage

// File: rtl/pwb_window_regs.sv
// Window register file and address matcher.
// Holds control/base/mask per window, reports a hit and the translated field
// of the lowest-numbered hitting window. Assumes ADDR_W >= TRANS_LO + TRANS_W.
module pwb_window_regs
    import pwb_pkg::*;
#(
    parameter int NWIN     = 2,
    parameter int ADDR_W   = 40,
    parameter int TRANS_W  = 16,
    parameter int WIN_W    = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [WIN_W-1:0]   cfg_win,
    input  logic [1:0]         cfg_sel,
    input  logic [ADDR_W-1:0]  cfg_wdata,
    input  logic [ADDR_W-1:0]  addr,
    output logic               hit,
    output logic [TRANS_W-1:0] trans,
    output logic [NWIN-1:0]    unpack_en
);
    logic [NWIN-1:0]    en_q;
    logic [NWIN-1:0]    hit_vec;
    logic [TRANS_W-1:0] trans_q [NWIN];

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        logic [ADDR_W-1:0] base_q;
        logic [ADDR_W-1:0] mask_q;
        logic              sel_me;

        assign sel_me = cfg_we && (cfg_win == WIN_W'(w));

        // Per-window register storage, cleared so the window starts disabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[w]      <= 1'b0;
                unpack_en[w] <= 1'b0;
                trans_q[w]   <= '0;
                base_q       <= '0;
                mask_q       <= '0;
            end else if (sel_me) begin
                case (cfg_sel)
                    CFG_CTRL: begin
                        en_q[w]      <= cfg_wdata[CTRL_EN_BIT];
                        unpack_en[w] <= cfg_wdata[CTRL_UNPK_BIT];
                        trans_q[w]   <= cfg_wdata[TRANS_W-1:0];
                    end
                    CFG_BASE: base_q <= cfg_wdata;
                    CFG_MASK: mask_q <= cfg_wdata;
                    default:  ;
                endcase
            end
        end

        // Masked compare of the incoming address against the window base.
        assign hit_vec[w] = en_q[w] && ((addr & mask_q) == (base_q & mask_q));
    end

    // Priority pick: lowest hitting window supplies the translation.
    always_comb begin
        trans = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) trans = trans_q[i];
        end
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/pwb_np_tracker.sv
// Outstanding non-posted write table.
// Allocates the lowest free slot for each non-posted write, keeps its AXI ID
// and releases the slot when the completion for that tag arrives.
// Assumes completions name only slots that are in use.
module pwb_np_tracker #(
    parameter int DEPTH = 4,
    parameter int ID_W  = 4,
    parameter int TAG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [ID_W-1:0]  alloc_id,
    output logic [TAG_W-1:0] alloc_tag,
    output logic             full,
    input  logic             release_i,
    input  logic [TAG_W-1:0] release_tag,
    output logic [ID_W-1:0]  release_id
);
    logic [DEPTH-1:0] busy_q;
    logic [ID_W-1:0]  id_q [DEPTH];

    // Find the lowest free slot.
    always_comb begin
        alloc_tag = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!busy_q[i]) alloc_tag = TAG_W'(i);
        end
    end

    assign full       = &busy_q;
    assign release_id = id_q[release_tag];

    // Slot occupancy and ID storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
            for (int i = 0; i < DEPTH; i++) id_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (alloc && alloc_tag == TAG_W'(i)) begin
                    busy_q[i] <= 1'b1;
                    id_q[i]   <= alloc_id;
                end else if (release_i && release_tag == TAG_W'(i)) begin
                    busy_q[i] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/pwb_bridge.sv
// Posted-write window bridge top.
// Accepts one AW and one W beat together, classifies the address against the
// windows, forwards a command and produces B either at once (posted) or on
// completion (non-posted). Assumes single-beat writes and a link that accepts
// completions only when cpl_ready is high.
module pwb_bridge
    import pwb_pkg::*;
#(
    parameter int NWIN     = 2,
    parameter int ADDR_W   = 40,
    parameter int DATA_W   = 32,
    parameter int ID_W     = 4,
    parameter int NP_DEPTH = 4,
    parameter int TRANS_W  = 16,
    parameter int TRANS_LO = 24,
    localparam int WIN_W   = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int TAG_W   = (NP_DEPTH > 1) ? $clog2(NP_DEPTH) : 1,
    localparam int STRB_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WIN_W-1:0]  cfg_win,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [NWIN-1:0]   unpack_en,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [ID_W-1:0]   s_awid,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [STRB_W-1:0] s_wstrb,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [ID_W-1:0]   s_bid,
    output logic [1:0]        s_bresp,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_posted,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic [STRB_W-1:0] cmd_strb,
    output logic [TAG_W-1:0]  cmd_tag,
    input  logic              cpl_valid,
    output logic              cpl_ready,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic              cpl_err
);
    logic               win_hit;
    logic [TRANS_W-1:0] win_trans;
    logic               np_full;
    logic [TAG_W-1:0]   np_tag;
    logic [ID_W-1:0]    cpl_id;
    logic               fire;
    logic               fire_post;
    logic               fire_np;
    logic               cpl_take;
    logic               b_pend_q;
    logic [ID_W-1:0]    b_id_q;
    logic [1:0]         b_resp_q;

    pwb_window_regs #(
        .NWIN(NWIN), .ADDR_W(ADDR_W), .TRANS_W(TRANS_W), .WIN_W(WIN_W)
    ) win_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .addr(s_awaddr), .hit(win_hit), .trans(win_trans), .unpack_en(unpack_en)
    );

    pwb_np_tracker #(
        .DEPTH(NP_DEPTH), .ID_W(ID_W), .TAG_W(TAG_W)
    ) trk_i (
        .clk(clk), .rst_n(rst_n),
        .alloc(fire_np), .alloc_id(s_awid), .alloc_tag(np_tag), .full(np_full),
        .release_i(cpl_take), .release_tag(cpl_tag), .release_id(cpl_id)
    );

    // Command is offered once both beats are present and the path has room.
    always_comb begin
        cmd_valid = s_awvalid && s_wvalid &&
                    (win_hit ? (!b_pend_q && !cpl_valid) : !np_full);
    end

    assign fire      = cmd_valid && cmd_ready;
    assign s_awready = fire;
    assign s_wready  = fire;
    assign fire_post = fire && win_hit;
    assign fire_np   = fire && !win_hit;

    assign cpl_ready = !b_pend_q;
    assign cpl_take  = cpl_valid && cpl_ready;

    // Build the outgoing address, substituting the translated field on a hit.
    always_comb begin
        cmd_addr = s_awaddr;
        if (win_hit) cmd_addr[TRANS_LO +: TRANS_W] = win_trans;
    end

    assign cmd_posted = win_hit;
    assign cmd_data   = s_wdata;
    assign cmd_strb   = s_wstrb;
    assign cmd_tag    = np_tag;

    // Single B response register, loaded by a completion or a posted accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_pend_q <= 1'b0;
            b_id_q   <= '0;
            b_resp_q <= RESP_OKAY;
        end else if (cpl_take) begin
            b_pend_q <= 1'b1;
            b_id_q   <= cpl_id;
            b_resp_q <= cpl_err ? RESP_SLVERR : RESP_OKAY;
        end else if (fire_post) begin
            b_pend_q <= 1'b1;
            b_id_q   <= s_awid;
            b_resp_q <= RESP_OKAY;
        end else if (s_bready) begin
            b_pend_q <= 1'b0;
        end
    end

    assign s_bvalid = b_pend_q;
    assign s_bid    = b_id_q;
    assign s_bresp  = b_resp_q;
endmodule

// File: rtl/pwb_bridge_chk.sv
// Protocol checker for pwb_bridge, attached by bind.
// Tracks the outstanding non-posted count from port traffic only.
module pwb_bridge_chk #(
    parameter int ID_W     = 4,
    parameter int NP_DEPTH = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            s_awvalid,
    input logic            s_awready,
    input logic [ID_W-1:0] s_awid,
    input logic            s_wvalid,
    input logic            s_bvalid,
    input logic            s_bready,
    input logic [ID_W-1:0] s_bid,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic            cmd_posted,
    input logic            cpl_valid,
    input logic            cpl_ready
);
    localparam int CNT_W = $clog2(NP_DEPTH + 1) + 1;
    logic [CNT_W-1:0] np_cnt;

    // Outstanding non-posted count seen at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) np_cnt <= '0;
        else np_cnt <= np_cnt
                     + CNT_W'(cmd_valid && cmd_ready && !cmd_posted)
                     - CNT_W'(cpl_valid && cpl_ready);
    end

    // R3
    posted_early_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_posted) |=> (s_bvalid && s_bid == $past(s_awid)));

    // R10
    b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bid)));

    // R5
    cpl_to_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_ready) |=> s_bvalid);

    // R7
    np_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        np_cnt <= CNT_W'(NP_DEPTH));

    // R8
    aw_needs_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_awready |-> (s_awvalid && s_wvalid && cmd_ready));
endmodule

bind pwb_bridge pwb_bridge_chk #(.ID_W(ID_W), .NP_DEPTH(NP_DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awid(s_awid),
    .s_wvalid(s_wvalid), .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bid(s_bid),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_posted(cmd_posted),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready)
);

// File: tb/pwb_bridge_tb_top.sv
module pwb_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] TR0 = 16'hABCD;
    localparam logic [15:0] TR1 = 16'h1234;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_win = '0;
    logic [1:0]  cfg_sel = '0;
    logic [39:0] cfg_wdata = '0;
    logic [1:0]  unpack_en;
    logic        s_awvalid = 1'b0, s_awready;
    logic [3:0]  s_awid = '0;
    logic [39:0] s_awaddr = '0;
    logic        s_wvalid = 1'b0, s_wready;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic        s_bvalid, s_bready = 1'b1;
    logic [3:0]  s_bid;
    logic [1:0]  s_bresp;
    logic        cmd_valid, cmd_ready = 1'b1, cmd_posted;
    logic [39:0] cmd_addr;
    logic [31:0] cmd_data;
    logic [3:0]  cmd_strb;
    logic [1:0]  cmd_tag;
    logic        cpl_valid = 1'b0, cpl_ready;
    logic [1:0]  cpl_tag = '0;
    logic        cpl_err = 1'b0;

    int checks = 0;
    int errors = 0;
    logic        g_posted;
    logic [39:0] g_addr;
    logic [1:0]  g_tag;
    logic [1:0]  tags [5];

    pwb_bridge dut_i (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input int win, input int sel, input logic [39:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_win = 1'(win); cfg_sel = 2'(sel); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drive_aw(input logic [3:0] id, input logic [39:0] addr);
        @(negedge clk);
        s_awvalid = 1'b1; s_wvalid = 1'b1;
        s_awid = id; s_awaddr = addr; s_wdata = {addr[23:0], 4'h0, id}; s_wstrb = 4'hF;
        #1;
    endtask

    // Wait for acceptance, capture the command, drop valids at the next negedge.
    task automatic finish_aw();
        while (!s_awready) begin
            @(negedge clk); #1;
        end
        g_posted = cmd_posted; g_addr = cmd_addr; g_tag = cmd_tag;
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0;
        #1;
    endtask

    task automatic complete(input logic [1:0] tag, input logic err);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_tag = tag; cpl_err = err;
        #1;
        while (!cpl_ready) begin
            @(negedge clk); #1;
        end
        @(negedge clk);
        cpl_valid = 1'b0; cpl_err = 1'b0;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(unpack_en == 2'b00, "R1 unpack", unpack_en, 0);
        chk(!s_bvalid, "R1 bvalid", s_bvalid, 0);
        chk(!cmd_valid, "R1 cmd_valid", cmd_valid, 0);

        // Program bases/masks; control left at zero.
        cfg(0, 1, 40'h10_0000_0000); cfg(0, 2, 40'hF0_0000_0000);
        cfg(1, 1, 40'h20_0000_0000); cfg(1, 2, 40'hF0_0000_0000);

        // R1: still disabled, a write inside window 0 is non-posted
        drive_aw(4'h1, 40'h10_0000_0040); finish_aw();
        chk(g_posted == 1'b0, "R1 disabled window posts", g_posted, 0);
        complete(g_tag, 1'b0);
        chk(s_bvalid && s_bid == 4'h1, "R1 B after completion", s_bid, 1);

        // R2 R3 R4 R5: sweep enable combinations against address regions
        for (int en = 0; en < 4; en++) begin
            cfg(0, 0, en[0] ? {8'h0, 1'b1, 15'h0, TR0} : {24'h0, TR0});
            cfg(1, 0, en[1] ? {8'h0, 1'b1, 15'h0, TR1} : {24'h0, TR1});
            for (int nib = 0; nib < 4; nib++) begin
                logic [39:0] a;
                logic [39:0] ea;
                bit h0, h1;
                a  = {4'(nib), 12'(en * 37 + nib), 24'(24'h35A1C0 + nib * 24'h1111)};
                h0 = en[0] && nib == 1;
                h1 = en[1] && nib == 2;
                ea = h0 ? {TR0, a[23:0]} : (h1 ? {TR1, a[23:0]} : a);
                drive_aw(4'(nib + 4), a);
                finish_aw();
                chk(g_posted == (h0 || h1), "R2 posted flag", g_posted, h0 || h1);
                chk(g_addr == ea, "R4 outgoing address", g_addr, ea);
                if (h0 || h1) begin
                    chk(s_bvalid && s_bid == 4'(nib + 4) && s_bresp == 2'b00,
                        "R3 early B", {s_bvalid, s_bid}, {1'b1, 4'(nib + 4)});
                end else begin
                    chk(!s_bvalid, "R5 no early B", s_bvalid, 0);
                    @(negedge clk); #1;
                    chk(!s_bvalid, "R5 still waiting", s_bvalid, 0);
                    complete(g_tag, 1'b0);
                    chk(s_bvalid && s_bid == 4'(nib + 4) && s_bresp == 2'b00,
                        "R5 B on completion", {s_bvalid, s_bid}, {1'b1, 4'(nib + 4)});
                end
            end
        end

        // R5: error completion gives SLVERR
        cfg(0, 0, 40'h0); cfg(1, 0, 40'h0);
        drive_aw(4'h9, 40'h33_0000_0000); finish_aw();
        complete(g_tag, 1'b1);
        chk(s_bvalid && s_bresp == 2'b10, "R5 error response", s_bresp, 2);

        // R9: unpack only, no enable -> exported but still non-posted
        cfg(0, 0, {8'h0, 2'b01, 14'h0, TR0});
        #1;
        chk(unpack_en == 2'b01, "R9 unpack export", unpack_en, 1);
        drive_aw(4'hA, 40'h10_0000_0100); finish_aw();
        chk(g_posted == 1'b0, "R9 unpack does not post", g_posted, 0);
        complete(g_tag, 1'b0);

        // R7: fill four slots, fifth stalls, out-of-order completion
        cfg(0, 0, 40'h0);
        for (int k = 0; k < 4; k++) begin
            drive_aw(4'(10 + k), 40'h00_0000_1000 + 40'(k));
            finish_aw();
            tags[k] = g_tag;
            chk(g_tag == 2'(k), "R7 slot allocation", g_tag, k);
        end
        drive_aw(4'hE, 40'h00_0000_2000);
        for (int c = 0; c < 3; c++) begin
            chk(!s_awready, "R7 fifth write stalls", s_awready, 0);
            @(negedge clk); #1;
        end
        complete(tags[2], 1'b0);
        chk(s_bvalid && s_bid == 4'd12, "R7 completion order ID", s_bid, 12);
        finish_aw();
        tags[4] = g_tag;
        chk(g_tag == tags[2], "R7 freed slot reused", g_tag, tags[2]);
        complete(tags[0], 1'b0);
        chk(s_bid == 4'd10, "R7 ID of slot 0", s_bid, 10);
        complete(tags[4], 1'b0);
        chk(s_bid == 4'hE, "R7 ID of reused slot", s_bid, 14);
        complete(tags[3], 1'b0);
        chk(s_bid == 4'd13, "R7 ID of slot 3", s_bid, 13);
        complete(tags[1], 1'b0);
        chk(s_bid == 4'd11, "R7 ID of slot 1", s_bid, 11);

        // R6: overlapping windows, lower index wins
        cfg(0, 0, {8'h0, 1'b1, 15'h0, TR0});
        cfg(1, 1, 40'h0); cfg(1, 2, 40'h0);
        cfg(1, 0, {8'h0, 1'b1, 15'h0, TR1});
        drive_aw(4'h2, 40'h1F_FF12_3456); finish_aw();
        chk(g_posted && g_addr == {TR0, 24'h123456}, "R6 priority low window", g_addr, {TR0, 24'h123456});
        drive_aw(4'h3, 40'h3F_FF65_4321); finish_aw();
        chk(g_posted && g_addr == {TR1, 24'h654321}, "R6 other window", g_addr, {TR1, 24'h654321});

        // R8: command port not ready blocks acceptance and early B
        @(negedge clk);
        cmd_ready = 1'b0;
        drive_aw(4'h5, 40'h10_0000_0000);
        for (int c = 0; c < 3; c++) begin
            chk(!s_awready && !s_wready, "R8 stall on cmd_ready", s_awready, 0);
            chk(!s_bvalid, "R8 no early B while stalled", s_bvalid, 0);
            @(negedge clk); #1;
        end
        cmd_ready = 1'b1;
        #1;
        finish_aw();
        chk(s_bvalid && s_bid == 4'h5, "R8 B after release", s_bid, 5);

        // R10: B held under backpressure; blocks posted writes and completions
        @(negedge clk);
        s_bready = 1'b0;
        drive_aw(4'h7, 40'h10_0000_0008); finish_aw();
        for (int c = 0; c < 2; c++) begin
            chk(s_bvalid && s_bid == 4'h7, "R10 B held", s_bid, 7);
            chk(!cpl_ready, "R10 cpl_ready low", cpl_ready, 0);
            @(negedge clk); #1;
        end
        drive_aw(4'h8, 40'h10_0000_000C);
        chk(!s_awready, "R10 posted write blocked", s_awready, 0);
        s_bready = 1'b1;
        finish_aw();
        chk(s_bvalid && s_bid == 4'h8, "R10 second B after drain", s_bid, 8);

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule